// File: doc/BRIEF.md
# Serial Character Receiver with Idle-Gap Timeout

This block receives asynchronous serial characters. Each character is eleven bit times long: a low start bit, eight data bits sent least significant bit first, an odd parity bit and a high stop bit. The line rests high. A clock divider built from the `CLK_HZ` and `BAUD` parameters (1200 bit/s by default) samples every bit at its middle. Each finished character appears on a single output register, together with a one-clock valid strobe and two error flags that belong to that character.

After every completed character the block watches the idle line for the falling start edge of the next one. If that edge has not appeared within `GAP_BITS` bit periods, the block emits a single one-clock timeout pulse. The default of 22 bit periods is two character times, which leaves margin over the bare 9.17 ms character. The timeout is judged by the missing start edge, not by a byte that arrives late. It fires once per idle gap and stays silent until another character has been received.

The control state machine has five states. RX_IDLE waits for a falling edge on the synchronized line. RX_START samples the middle of the start bit. It returns to RX_IDLE on a glitch (the line reads high) or moves on to RX_DATA (the line reads low). RX_DATA shifts in eight bits and then goes to RX_PARITY. RX_PARITY captures the parity bit and goes to RX_STOP. RX_STOP samples the stop bit, publishes the character and returns to RX_IDLE.

Top module: `uart_rx_gap`

## Requirements
- R1: With the line idle high, a falling edge starts a character. Data bits are taken least significant bit first at mid-bit, and the byte appears on `rx_data` together with `rx_valid`.
- R2: `rx_valid` is high for exactly one clock per received character. `rx_data`, `parity_err` and `frame_err` change only in a cycle where `rx_valid` is high and hold their values otherwise.
- R3: Parity is odd. `parity_err` is 1 when the eight data bits together with the parity bit hold an even number of ones, and 0 otherwise.
- R4: A stop bit sampled low sets `frame_err` to 1 for that character, and the byte is still delivered with `rx_valid`.
- R5: A start bit that reads high at its mid-point is treated as a glitch. No byte is produced and the receiver returns to idle.
- R6: When no start edge follows a completed character, `rx_timeout` is high for one clock. It rises exactly `GAP_BITS` × (`CLK_HZ`/`BAUD`) clocks after the `rx_valid` of that character.
- R7: The timeout fires at most once per idle gap and does not fire again until another character completes.
- R8: After reset, no timeout is raised until the first character has completed.
- R9: A start edge inside the window suppresses that timeout, so a gapless stream, or one with gaps shorter than the window, raises no timeout.
- R10: In reset, `rx_valid`, `rx_timeout`, `parity_err`, `frame_err` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock strobe when a character completes |
| parity_err | output | 1 | Odd-parity check failed for the last character |
| frame_err | output | 1 | Stop bit of the last character was low |
| rx_timeout | output | 1 | One-clock pulse when the idle gap exceeds the window |

## Verification
The bench measures the exact cycle distance from the valid strobe to the timeout pulse. A window counter that is off by one clock or one bit period shows up as a wrong distance. It then keeps the line idle far beyond the window, so a timer that is not disarmed after firing is caught pulsing again. Short glitches on a fresh line would otherwise produce a phantom byte or arm the timer without any character. Back-to-back and short-gap streams would raise a spurious timeout if a start edge failed to cancel the window. Bad parity and a low stop bit must each set only their own flag while the byte is still delivered.

// File: rtl/uart_rx_gap_pkg.sv
package uart_rx_gap_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    // Odd parity holds when the data bits plus the parity bit have an odd count of ones
    function automatic logic odd_parity_bad(input logic [31:0] bits, input int unsigned width,
                                            input logic par);
        logic acc;
        acc = par;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(width)) acc = acc ^ bits[i];
        end
        return ~acc;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int unsigned CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_half,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(CLKS_PER_BIT + 1);
    localparam int unsigned HALF  = CLKS_PER_BIT / 2;
    localparam logic [CNT_W-1:0] HALF_RL = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL_RL = CNT_W'(CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (load_half) cnt_q <= HALF_RL;
        else if (run)       cnt_q <= tick ? FULL_RL : cnt_q - 1'b1;
        else                cnt_q <= '0;
    end
endmodule

// File: rtl/rx_gap_timer.sv
module rx_gap_timer #(
    parameter int unsigned CLKS_PER_BIT = 16,
    parameter int unsigned GAP_BITS     = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hold,
    output logic expired
);
    localparam int unsigned CLK_W = $clog2(CLKS_PER_BIT + 1);
    localparam int unsigned BIT_W = $clog2(GAP_BITS + 1);
    localparam logic [CLK_W-1:0] CLK_LAST = CLK_W'(CLKS_PER_BIT - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(GAP_BITS - 1);

    logic             armed_q;
    logic [CLK_W-1:0] clk_cnt_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic             pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            clk_cnt_q <= '0;
            bit_cnt_q <= '0;
            pulse_q   <= 1'b0;
        end else if (arm) begin
            armed_q   <= 1'b1;
            clk_cnt_q <= '0;
            bit_cnt_q <= '0;
            pulse_q   <= 1'b0;
        end else if (hold) begin
            clk_cnt_q <= '0;
            bit_cnt_q <= '0;
            pulse_q   <= 1'b0;
        end else if (armed_q) begin
            pulse_q <= 1'b0;
            if (clk_cnt_q == CLK_LAST) begin
                clk_cnt_q <= '0;
                if (bit_cnt_q == BIT_LAST) begin
                    bit_cnt_q <= '0;
                    armed_q   <= 1'b0;
                    pulse_q   <= 1'b1;
                end else begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end else begin
                clk_cnt_q <= clk_cnt_q + 1'b1;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign expired = pulse_q;
endmodule

// File: rtl/uart_rx_gap.sv
module uart_rx_gap
    import uart_rx_gap_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BAUD      = 1200,
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned GAP_BITS  = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_pin,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 rx_timeout
);
    localparam int unsigned CLKS_PER_BIT = CLK_HZ / BAUD;
    localparam int unsigned IDX_W        = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_e state_q, state_d;

    logic                 rx_s;
    logic                 rx_prev_q;
    logic                 fall;
    logic                 busy;
    logic                 tick;
    logic                 start_go;
    logic                 done;
    logic [IDX_W-1:0]     bit_idx_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 par_q;
    logic [31:0]          shreg_ext;

    rx_line_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_pin),
        .dout (rx_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_prev_q <= 1'b1;
        else        rx_prev_q <= rx_s;
    end

    assign fall     = rx_prev_q & ~rx_s;
    assign busy     = (state_q != RX_IDLE);
    assign start_go = (state_q == RX_IDLE) && fall;
    assign done     = (state_q == RX_STOP) && tick;

    rx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_bit_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_half(start_go),
        .run      (busy),
        .tick     (tick)
    );

    rx_gap_timer #(
        .CLKS_PER_BIT(CLKS_PER_BIT),
        .GAP_BITS    (GAP_BITS)
    ) u_gap_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (done),
        .hold   (busy),
        .expired(rx_timeout)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (fall) state_d = RX_START;
            RX_START:  if (tick) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (tick && bit_idx_q == IDX_LAST) state_d = RX_PARITY;
            RX_PARITY: if (tick) state_d = RX_STOP;
            RX_STOP:   if (tick) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    assign shreg_ext = 32'(shreg_q);

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q  <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            unique case (state_q)
                RX_IDLE: bit_idx_q <= '0;
                RX_START: bit_idx_q <= '0;
                RX_DATA: begin
                    if (tick) begin
                        shreg_q   <= {rx_s, shreg_q[DATA_BITS-1:1]};
                        bit_idx_q <= bit_idx_q + 1'b1;
                    end
                end
                RX_PARITY: if (tick) par_q <= rx_s;
                RX_STOP: begin
                    if (tick) begin
                        rx_valid   <= 1'b1;
                        rx_data    <= shreg_q;
                        parity_err <= odd_parity_bad(shreg_ext, DATA_BITS, par_q);
                        frame_err  <= ~rx_s;
                    end
                end
                default: bit_idx_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_gap_chk.sv
module uart_rx_gap_chk #(
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 parity_err,
    input logic                 frame_err,
    input logic                 rx_timeout,
    input logic                 busy
);
    logic seen_char_q;
    logic fired_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_char_q <= 1'b0;
            fired_q     <= 1'b0;
        end else begin
            if (rx_valid) seen_char_q <= 1'b1;
            if (rx_valid)        fired_q <= 1'b0;
            else if (rx_timeout) fired_q <= 1'b1;
        end
    end

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data) && $stable(parity_err) && $stable(frame_err));

    p_timeout_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> !rx_timeout);

    p_once_per_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> !fired_q);

    p_needs_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> seen_char_q);

    p_idle_before_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> !$past(busy));

    p_no_timeout_with_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !rx_timeout);
endmodule

bind uart_rx_gap uart_rx_gap_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .parity_err(parity_err),
    .frame_err (frame_err),
    .rx_timeout(rx_timeout),
    .busy      (busy)
);

// File: tb/tb_uart_rx_gap.sv
module tb_uart_rx_gap;
    localparam int CPB  = 16;
    localparam int GAP  = 22;
    localparam int BAUD = 1200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, frame_err, rx_timeout;

    always #2 clk = ~clk;

    uart_rx_gap #(.CLK_HZ(BAUD*CPB), .BAUD(BAUD), .DATA_BITS(8), .GAP_BITS(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_data(rx_data),
        .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err),
        .rx_timeout(rx_timeout)
    );

    int checks = 0, errors = 0;
    int cyc = 0, vcount = 0, tcount = 0, width_err = 0, chg_err = 0;
    int last_v_cyc = 0, last_t_cyc = 0;
    logic [7:0] last_data = '0, prev_data = '0;
    logic last_perr = 0, last_ferr = 0, prev_v = 0, prev_p = 0, prev_f = 0;
    bit finished = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (rx_valid) begin
                vcount++; last_v_cyc = cyc;
                last_data = rx_data; last_perr = parity_err; last_ferr = frame_err;
                if (prev_v) width_err++;
            end else if (rx_data != prev_data || parity_err != prev_p || frame_err != prev_f) begin
                chg_err++;
            end
            if (rx_timeout) begin tcount++; last_t_cyc = cyc; end
        end
        prev_v = rx_valid; prev_data = rx_data; prev_p = parity_err; prev_f = frame_err;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_bits(input int n);
        rx_pin = 1'b1;
        repeat (n*CPB) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input int gap);
        rx_pin = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_pin = d[i];
            repeat (CPB) @(negedge clk);
        end
        rx_pin = (~^d) ^ bad_par;
        repeat (CPB) @(negedge clk);
        rx_pin = ~bad_stop;
        repeat (CPB) @(negedge clk);
        idle_bits(gap);
    endtask

    task automatic t_reset;
        chk("R10 valid", rx_valid, 0);
        chk("R10 timeout", rx_timeout, 0);
        chk("R10 data", rx_data, 0);
        chk("R10 flags", {parity_err, frame_err}, 0);
    endtask

    task automatic t_no_timeout_fresh;
        idle_bits(40);
        chk("R8 no timeout before first char", tcount, 0);
    endtask

    task automatic t_glitch;
        int v0 = vcount;
        rx_pin = 1'b0;
        repeat (4) @(negedge clk);
        idle_bits(40);
        chk("R5 glitch gives no byte", vcount, v0);
        chk("R8 glitch does not arm timeout", tcount, 0);
    endtask

    task automatic t_good(input logic [7:0] d);
        int v0 = vcount;
        send_frame(d, 0, 0, 2);
        chk("R1 byte count", vcount, v0 + 1);
        chk("R1 data", last_data, d);
        chk("R3 good parity", last_perr, 0);
        chk("R4 good stop", last_ferr, 0);
    endtask

    task automatic t_parity_bad;
        send_frame(8'h5A, 1, 0, 2);
        chk("R3 parity error flagged", last_perr, 1);
        chk("R3 data still delivered", last_data, 8'h5A);
        chk("R4 stop fine", last_ferr, 0);
    endtask

    task automatic t_frame_bad;
        int v0 = vcount;
        send_frame(8'hC3, 0, 1, 3);
        chk("R4 framing error flagged", last_ferr, 1);
        chk("R4 byte still valid", vcount, v0 + 1);
        chk("R4 data", last_data, 8'hC3);
        chk("R3 parity fine", last_perr, 0);
    endtask

    task automatic t_timeout;
        int t0;
        idle_bits(40);
        t0 = tcount;
        send_frame(8'h96, 0, 0, 30);
        chk("R6 one timeout", tcount, t0 + 1);
        chk("R6 exact distance", last_t_cyc - last_v_cyc, GAP*CPB);
        idle_bits(80);
        chk("R7 no re-fire in same gap", tcount, t0 + 1);
    endtask

    task automatic t_stream;
        int t0 = tcount;
        logic [7:0] vals[4] = '{8'h01, 8'h80, 8'h7E, 8'hE7};
        for (int i = 0; i < 4; i++) send_frame(vals[i], 0, 0, 0);
        chk("R9 gapless stream no timeout", tcount, t0);
        chk("R1 last stream byte", last_data, 8'hE7);
        for (int i = 0; i < 3; i++) send_frame(vals[i], 0, 0, 18);
        chk("R9 short gaps no timeout", tcount, t0);
        idle_bits(30);
        chk("R7 fires again after new char", tcount, t0 + 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_no_timeout_fresh();
        t_glitch();
        t_good(8'hA5);
        t_good(8'h00);
        t_good(8'hFF);
        t_good(8'h3C);
        t_parity_bad();
        t_frame_bad();
        t_timeout();
        t_stream();
        chk("R2 valid single clock", width_err, 0);
        chk("R2 outputs held between bytes", chg_err, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule